// File: doc/BRIEF.md
# Trap Cause and Trap Value Capture

This block sits beside the pipeline of a small RISC-V style core and turns exception requests from four places into one trap record. The places are the fetch stage, the decoder, the CSR unit and the load/store stage. For each cycle it evaluates every source, keeps the one from the oldest stage, and produces a trap strobe together with a 4-bit exception code and a trap value. The interrupt flag of the recorded cause is always zero, because every source handled here is an exception. The trap value is also written into one of two bad-address CSRs, machine or supervisor, and both can be read back by CSR address.

Each source has its own rule for the trap value. The fetch side reports the exact address whose translation failed. This includes the case of a halfword-aligned fetch, where the translation of the halfword below the pc fails, or the translation of the halfword past the pc fails when the instruction is 32 bits long. The load/store side checks a data access in a fixed order: alignment first, then translation, then access permission. A cause that has no defined value always writes zero, so no earlier value is left behind. Translation, delegation policy, interrupts and flushing are handled elsewhere. Here `trap_to_s` only says which bad-address CSR receives the value.

Top module: `trap_capture`

## Requirements
- R1: `dec_illegal` gives cause 2 with the trap value equal to `dec_instr`.
- R2: `csr_illegal` gives cause 2 with a trap value of zero.
- R3: A fetch with `fetch_pc[1]`=0 and `fetch_xf_first` set gives cause 12 with the trap value equal to `fetch_pc`. In this case `fetch_xf_second` and `fetch_upper32` are ignored.
- R4: A fetch with `fetch_pc[1]`=1 and `fetch_xf_first` gives cause 12 with value `fetch_pc`-2. If `fetch_xf_first` is clear and both `fetch_upper32` and `fetch_xf_second` are set, it gives cause 12 with value `fetch_pc`+2. `fetch_xf_second` without `fetch_upper32` raises nothing.
- R5: A data access is misaligned when `lsu_addr` AND (2^`lsu_size` − 1) is nonzero (`lsu_size` is log2 of the byte count). A misaligned access gives cause 4 for a load or 6 for a store (`lsu_store`=1), with value `lsu_addr`. This outranks `lsu_xf` and `lsu_af`.
- R6: An aligned access with `lsu_xf` gives cause 13 for a load or 15 for a store, with value `lsu_addr`. This outranks `lsu_af`.
- R7: An aligned, translated access with `lsu_af` gives cause 5 for a load or 7 for a store, with value `lsu_addr`.
- R8: A fetch with `fetch_access_fault` and no fetch translation fault gives cause 1 with a trap value of zero, replacing any earlier value.
- R9: Priority from highest to lowest is load/store, CSR, decoder, fetch. A `lsu_valid` access that has no fault does not block lower sources.
- R10: `trap_taken`, `trap_cause` and `trap_value` update on the clock edge after the request. In a cycle with no fault, `trap_taken` is 0 and cause, value and both CSRs keep their contents.
- R11: On a trap, the value is written to the machine CSR when `trap_to_s`=0 and to the supervisor CSR when it is 1. The other CSR keeps its value.
- R12: `rd_data` returns the machine CSR for `rd_addr`=0x343, the supervisor CSR for 0x143, and zero otherwise. It is registered one cycle after the address.
- R13: A synchronous reset clears the strobe, cause, value, both CSRs and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch result present |
| fetch_pc | input | 32 | Fetch pc |
| fetch_xf_first | input | 1 | Translation failed for the first halfword address |
| fetch_upper32 | input | 1 | Upper halfword begins a 32-bit instruction |
| fetch_xf_second | input | 1 | Translation failed for pc+2 |
| fetch_access_fault | input | 1 | Instruction bus access fault |
| dec_illegal | input | 1 | Decoder found an illegal instruction |
| dec_instr | input | 32 | Raw instruction word |
| csr_illegal | input | 1 | Illegal CSR access or CSR-side illegal instruction |
| lsu_valid | input | 1 | Data access present |
| lsu_store | input | 1 | 1 = store, 0 = load |
| lsu_size | input | 2 | log2 of access bytes |
| lsu_addr | input | 32 | Virtual data address |
| lsu_xf | input | 1 | Data translation failed |
| lsu_af | input | 1 | Data access fault |
| trap_to_s | input | 1 | Target supervisor bad-address CSR |
| trap_taken | output | 1 | Trap strobe |
| trap_cause | output | 4 | Exception code |
| trap_value | output | 32 | Trap value |
| rd_addr | input | 12 | CSR read address |
| rd_data | output | 32 | CSR read data |

## Verification
Random cycles raise any mix of the four sources at the same time, so the priority order and the rule that a clean access does not block are both tested against a bench model. Targeted cycles cover the rest. A halfword fetch faulting on the lower address is told apart from one faulting on the upper address. A second-address fault without a 32-bit instruction must leave everything unchanged. A misaligned access that also carries translation and access faults must report the misalignment. A fetch access fault must overwrite an old nonzero value with zero. Reads at both CSR addresses and at an unrelated address, after traps aimed at each privilege level, separate the two copies.

// File: rtl/trap_cap_pkg.sv
package trap_cap_pkg;
  localparam int CAUSE_W = 4;
  localparam int NSRC    = 4;
  localparam int NPRIV   = 2;
  // source slots, index 0 has the highest priority
  localparam int SRC_LSU   = 0;
  localparam int SRC_CSR   = 1;
  localparam int SRC_DEC   = 2;
  localparam int SRC_FETCH = 3;

  typedef enum logic [CAUSE_W-1:0] {
    EXC_IACCESS  = 4'd1,
    EXC_ILLEGAL  = 4'd2,
    EXC_LD_MIS   = 4'd4,
    EXC_LD_ACC   = 4'd5,
    EXC_ST_MIS   = 4'd6,
    EXC_ST_ACC   = 4'd7,
    EXC_IPAGE    = 4'd12,
    EXC_LD_PAGE  = 4'd13,
    EXC_ST_PAGE  = 4'd15
  } exc_code_e;
endpackage

// File: rtl/fetch_fault_eval.sv
module fetch_fault_eval
  import trap_cap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                fetch_valid,
  input  logic [XLEN-1:0]     fetch_pc,
  input  logic                xf_first,
  input  logic                upper32,
  input  logic                xf_second,
  input  logic                access_fault,
  output logic                req,
  output logic [CAUSE_W-1:0]  cause,
  output logic [XLEN-1:0]     value
);
  localparam logic [XLEN-1:0] HALF = XLEN'(2);

  logic [XLEN-1:0] first_addr;
  logic [XLEN-1:0] second_addr;
  logic            straddle;

  assign straddle    = fetch_pc[1];
  assign first_addr  = straddle ? fetch_pc - HALF : fetch_pc;
  assign second_addr = fetch_pc + HALF;

  always_comb begin
    req   = 1'b0;
    cause = EXC_IPAGE;
    value = '0;
    if (fetch_valid) begin
      if (xf_first) begin
        req   = 1'b1;
        value = first_addr;
      end else if (straddle && upper32 && xf_second) begin
        req   = 1'b1;
        value = second_addr;
      end else if (access_fault) begin
        req   = 1'b1;
        cause = EXC_IACCESS;
      end
    end
  end
endmodule

// File: rtl/lsu_fault_eval.sv
module lsu_fault_eval
  import trap_cap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int SIZE_W = 2
) (
  input  logic                lsu_valid,
  input  logic                lsu_store,
  input  logic [SIZE_W-1:0]   lsu_size,
  input  logic [XLEN-1:0]     lsu_addr,
  input  logic                lsu_xf,
  input  logic                lsu_af,
  output logic                req,
  output logic [CAUSE_W-1:0]  cause,
  output logic [XLEN-1:0]     value
);
  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  logic [XLEN-1:0] low_mask;
  logic            misaligned;

  assign low_mask   = (ONE << lsu_size) - ONE;
  assign misaligned = |(lsu_addr & low_mask);
  assign value      = lsu_addr;

  // ordered checks: alignment, translation, access
  always_comb begin
    req   = lsu_valid;
    cause = lsu_store ? EXC_ST_MIS : EXC_LD_MIS;
    if (!misaligned) begin
      if (lsu_xf)      cause = lsu_store ? EXC_ST_PAGE : EXC_LD_PAGE;
      else if (lsu_af) cause = lsu_store ? EXC_ST_ACC : EXC_LD_ACC;
      else             req   = 1'b0;
    end
  end
endmodule

// File: rtl/trap_select.sv
module trap_select
  import trap_cap_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREQ  = NSRC
) (
  input  logic [NREQ-1:0]              req,
  input  logic [NREQ-1:0][CAUSE_W-1:0] cause,
  input  logic [NREQ-1:0][XLEN-1:0]    value,
  output logic                         any,
  output logic [CAUSE_W-1:0]           sel_cause,
  output logic [XLEN-1:0]              sel_value
);
  always_comb begin
    any       = 1'b0;
    sel_cause = '0;
    sel_value = '0;
    // walk from lowest priority so slot 0 lands last
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        any       = 1'b1;
        sel_cause = cause[i];
        sel_value = value[i];
      end
    end
  end
endmodule

// File: rtl/bad_addr_file.sv
module bad_addr_file
  import trap_cap_pkg::*;
#(
  parameter int                 XLEN   = 32,
  parameter int                 CSR_AW = 12,
  parameter logic [CSR_AW-1:0]  M_ADDR = 12'h343,
  parameter logic [CSR_AW-1:0]  S_ADDR = 12'h143
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_priv,
  input  logic [XLEN-1:0]    wr_data,
  input  logic [CSR_AW-1:0]  rd_addr,
  output logic [XLEN-1:0]    rd_data
);
  logic [NPRIV-1:0][XLEN-1:0] bad_q;

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPRIV; p++) begin
      if (rst) bad_q[p] <= '0;
      else if (wr_en && (int'(wr_priv) == p)) bad_q[p] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  rd_data <= '0;
    else if (rd_addr == M_ADDR) rd_data <= bad_q[0];
    else if (rd_addr == S_ADDR) rd_data <= bad_q[1];
    else                      rd_data <= '0;
  end
endmodule

// File: rtl/trap_capture.sv
module trap_capture
  import trap_cap_pkg::*;
#(
  parameter int                 XLEN   = 32,
  parameter int                 SIZE_W = 2,
  parameter int                 CSR_AW = 12,
  parameter logic [CSR_AW-1:0]  M_ADDR = 12'h343,
  parameter logic [CSR_AW-1:0]  S_ADDR = 12'h143
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_valid,
  input  logic [XLEN-1:0]    fetch_pc,
  input  logic               fetch_xf_first,
  input  logic               fetch_upper32,
  input  logic               fetch_xf_second,
  input  logic               fetch_access_fault,
  input  logic               dec_illegal,
  input  logic [XLEN-1:0]    dec_instr,
  input  logic               csr_illegal,
  input  logic               lsu_valid,
  input  logic               lsu_store,
  input  logic [SIZE_W-1:0]  lsu_size,
  input  logic [XLEN-1:0]    lsu_addr,
  input  logic               lsu_xf,
  input  logic               lsu_af,
  input  logic               trap_to_s,
  output logic               trap_taken,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [XLEN-1:0]    trap_value,
  input  logic [CSR_AW-1:0]  rd_addr,
  output logic [XLEN-1:0]    rd_data
);
  logic [NSRC-1:0]              src_req;
  logic [NSRC-1:0][CAUSE_W-1:0] src_cause;
  logic [NSRC-1:0][XLEN-1:0]    src_value;
  logic                         hit;
  logic [CAUSE_W-1:0]           hit_cause;
  logic [XLEN-1:0]              hit_value;

  lsu_fault_eval #(.XLEN(XLEN), .SIZE_W(SIZE_W)) u_lsu (
    .lsu_valid (lsu_valid), .lsu_store (lsu_store), .lsu_size (lsu_size),
    .lsu_addr  (lsu_addr),  .lsu_xf    (lsu_xf),    .lsu_af   (lsu_af),
    .req (src_req[SRC_LSU]), .cause (src_cause[SRC_LSU]), .value (src_value[SRC_LSU])
  );

  assign src_req[SRC_CSR]   = csr_illegal;
  assign src_cause[SRC_CSR] = EXC_ILLEGAL;
  assign src_value[SRC_CSR] = '0;

  assign src_req[SRC_DEC]   = dec_illegal;
  assign src_cause[SRC_DEC] = EXC_ILLEGAL;
  assign src_value[SRC_DEC] = dec_instr;

  fetch_fault_eval #(.XLEN(XLEN)) u_fetch (
    .fetch_valid (fetch_valid), .fetch_pc (fetch_pc),
    .xf_first (fetch_xf_first), .upper32 (fetch_upper32),
    .xf_second (fetch_xf_second), .access_fault (fetch_access_fault),
    .req (src_req[SRC_FETCH]), .cause (src_cause[SRC_FETCH]), .value (src_value[SRC_FETCH])
  );

  trap_select #(.XLEN(XLEN), .NREQ(NSRC)) u_sel (
    .req (src_req), .cause (src_cause), .value (src_value),
    .any (hit), .sel_cause (hit_cause), .sel_value (hit_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_taken <= 1'b0;
      trap_cause <= '0;
      trap_value <= '0;
    end else begin
      trap_taken <= hit;
      if (hit) begin
        trap_cause <= hit_cause;
        trap_value <= hit_value;
      end
    end
  end

  bad_addr_file #(.XLEN(XLEN), .CSR_AW(CSR_AW), .M_ADDR(M_ADDR), .S_ADDR(S_ADDR)) u_bad (
    .clk (clk), .rst (rst), .wr_en (hit), .wr_priv (trap_to_s), .wr_data (hit_value),
    .rd_addr (rd_addr), .rd_data (rd_data)
  );
endmodule

// File: rtl/trap_capture_chk.sv
module trap_capture_chk #(
  parameter int XLEN   = 32,
  parameter int SIZE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_valid,
  input logic [XLEN-1:0]   fetch_pc,
  input logic              fetch_xf_first,
  input logic              dec_illegal,
  input logic [XLEN-1:0]   dec_instr,
  input logic              csr_illegal,
  input logic              lsu_valid,
  input logic              lsu_store,
  input logic [SIZE_W-1:0] lsu_size,
  input logic [XLEN-1:0]   lsu_addr,
  input logic              trap_taken,
  input logic [3:0]        trap_cause,
  input logic [XLEN-1:0]   trap_value
);
  assert_decode_illegal_R1: assert property (@(posedge clk) disable iff (rst)
    (dec_illegal && !lsu_valid && !csr_illegal) |=>
      (trap_taken && trap_cause == 4'd2 && trap_value == $past(dec_instr)));

  assert_csr_illegal_R2: assert property (@(posedge clk) disable iff (rst)
    (csr_illegal && !lsu_valid) |=> (trap_taken && trap_cause == 4'd2 && trap_value == '0));

  assert_fetch_page_R3: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !fetch_pc[1] && fetch_xf_first && !lsu_valid && !csr_illegal && !dec_illegal) |=>
      (trap_taken && trap_cause == 4'd12 && trap_value == $past(fetch_pc)));

  assert_load_misalign_R5: assert property (@(posedge clk) disable iff (rst)
    (lsu_valid && !lsu_store && lsu_size == SIZE_W'(1) && lsu_addr[0]) |=>
      (trap_taken && trap_cause == 4'd4 && trap_value == $past(lsu_addr)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(fetch_valid || dec_illegal || csr_illegal || lsu_valid) |=>
      (!trap_taken && $stable(trap_cause) && $stable(trap_value)));

  assert_cause_set_R9: assert property (@(posedge clk) disable iff (rst)
    trap_taken |-> (trap_cause inside {4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7, 4'd12, 4'd13, 4'd15}));
endmodule

bind trap_capture trap_capture_chk #(.XLEN(XLEN), .SIZE_W(SIZE_W)) u_chk (
  .clk (clk), .rst (rst), .fetch_valid (fetch_valid), .fetch_pc (fetch_pc),
  .fetch_xf_first (fetch_xf_first), .dec_illegal (dec_illegal), .dec_instr (dec_instr),
  .csr_illegal (csr_illegal), .lsu_valid (lsu_valid), .lsu_store (lsu_store),
  .lsu_size (lsu_size), .lsu_addr (lsu_addr), .trap_taken (trap_taken),
  .trap_cause (trap_cause), .trap_value (trap_value)
);

// File: tb/sim_trap_capture.sv
`timescale 1ns/1ps
module sim_trap_capture;
  logic        clk = 1'b0;
  logic        rst;
  logic        fetch_valid, fetch_xf_first, fetch_upper32, fetch_xf_second, fetch_access_fault;
  logic [31:0] fetch_pc, dec_instr, lsu_addr;
  logic        dec_illegal, csr_illegal, lsu_valid, lsu_store, lsu_xf, lsu_af, trap_to_s;
  logic [1:0]  lsu_size;
  logic        trap_taken;
  logic [3:0]  trap_cause;
  logic [31:0] trap_value, rd_data;
  logic [11:0] rd_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0]  m_cause;
  logic [31:0] m_tval;
  logic [31:0] m_bad [2];

  always #10 clk = ~clk;

  trap_capture u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    fetch_valid = 0; fetch_pc = 0; fetch_xf_first = 0; fetch_upper32 = 0;
    fetch_xf_second = 0; fetch_access_fault = 0; dec_illegal = 0; dec_instr = 0;
    csr_illegal = 0; lsu_valid = 0; lsu_store = 0; lsu_size = 0; lsu_addr = 0;
    lsu_xf = 0; lsu_af = 0; trap_to_s = 0; rd_addr = 12'h000;
  endtask

  // expected {taken, cause, value} from the requirements
  function automatic logic [36:0] model();
    logic [31:0] mask;
    mask = (32'd1 << lsu_size) - 32'd1;
    if (lsu_valid) begin
      if ((lsu_addr & mask) != 0) return {1'b1, (lsu_store ? 4'd6 : 4'd4), lsu_addr};   // R5
      if (lsu_xf) return {1'b1, (lsu_store ? 4'd15 : 4'd13), lsu_addr};                 // R6
      if (lsu_af) return {1'b1, (lsu_store ? 4'd7 : 4'd5), lsu_addr};                   // R7
    end
    if (csr_illegal) return {1'b1, 4'd2, 32'd0};                                        // R2
    if (dec_illegal) return {1'b1, 4'd2, dec_instr};                                    // R1
    if (fetch_valid) begin
      if (fetch_xf_first) return {1'b1, 4'd12, (fetch_pc[1] ? fetch_pc - 32'd2 : fetch_pc)};
      if (fetch_pc[1] && fetch_upper32 && fetch_xf_second) return {1'b1, 4'd12, fetch_pc + 32'd2};
      if (fetch_access_fault) return {1'b1, 4'd1, 32'd0};                               // R8
    end
    return {1'b0, 4'd0, 32'd0};
  endfunction

  function automatic string tag_of(input logic [3:0] c, input bit taken);
    if (!taken) return "R10";
    case (c)
      4'd1: return "R8";
      4'd2: return "R1/R2";
      4'd4, 4'd6: return "R5";
      4'd13, 4'd15: return "R6";
      4'd5, 4'd7: return "R7";
      default: return "R3/R4";
    endcase
  endfunction

  task automatic step(input string tag);
    logic [36:0] e;
    logic [31:0] exp_rd;
    string t;
    e = model();
    exp_rd = (rd_addr == 12'h343) ? m_bad[0] : (rd_addr == 12'h143) ? m_bad[1] : 32'd0;
    if (e[36]) begin
      m_cause = e[35:32];
      m_tval  = e[31:0];
      m_bad[trap_to_s] = e[31:0];
    end
    t = (tag == "") ? tag_of(e[35:32], e[36]) : tag;
    @(posedge clk); @(negedge clk);
    chk(trap_taken == e[36], {t, " strobe"}, 32'(trap_taken), 32'(e[36]));
    chk(trap_cause == m_cause, {t, " cause"}, 32'(trap_cause), 32'(m_cause));
    chk(trap_value == m_tval, {t, " value"}, trap_value, m_tval);
    chk(rd_data == exp_rd, "R12/R11 readback", rd_data, exp_rd);
  endtask

  initial begin
    void'($urandom(32'd4242));
    clear_in();
    rst = 1;
    m_cause = 0; m_tval = 0; m_bad[0] = 0; m_bad[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R13 reset state
    chk(trap_taken == 0, "R13 strobe", 32'(trap_taken), 0);
    chk(trap_cause == 0, "R13 cause", 32'(trap_cause), 0);
    chk(trap_value == 0, "R13 value", trap_value, 0);
    chk(rd_data == 0, "R13 readback", rd_data, 0);

    // R4 lower halfword translation fault
    clear_in(); fetch_valid = 1; fetch_pc = 32'h0000_1002; fetch_xf_first = 1; fetch_xf_second = 1;
    fetch_upper32 = 1; step("R4 first");
    // R4 upper halfword translation fault
    clear_in(); fetch_valid = 1; fetch_pc = 32'h0000_2006; fetch_upper32 = 1; fetch_xf_second = 1;
    step("R4 second");
    // R4 second fault ignored without 32-bit instruction
    clear_in(); fetch_valid = 1; fetch_pc = 32'h0000_300A; fetch_xf_second = 1; step("R4 ignored");
    // R3 aligned: second flag ignored
    clear_in(); fetch_valid = 1; fetch_pc = 32'h0000_4000; fetch_upper32 = 1; fetch_xf_second = 1;
    step("R3 ignored");
    clear_in(); fetch_valid = 1; fetch_pc = 32'h0000_4004; fetch_xf_first = 1; step("R3 aligned");
    // R5 misalignment beats translation and access faults
    clear_in(); lsu_valid = 1; lsu_size = 2; lsu_addr = 32'h0000_0102; lsu_xf = 1; lsu_af = 1;
    step("R5 precedence");
    clear_in(); lsu_valid = 1; lsu_store = 1; lsu_size = 1; lsu_addr = 32'h0000_0203; lsu_xf = 1;
    step("R5 store");
    // R6 beats R7
    clear_in(); lsu_valid = 1; lsu_size = 2; lsu_addr = 32'h0000_0300; lsu_xf = 1; lsu_af = 1;
    step("R6 precedence");
    clear_in(); lsu_valid = 1; lsu_size = 0; lsu_addr = 32'h0000_0401; lsu_af = 1; step("R7 byte");
    // R9 clean access does not block decoder
    clear_in(); lsu_valid = 1; lsu_size = 2; lsu_addr = 32'h0000_0500; dec_illegal = 1;
    dec_instr = 32'hDEAD_BEEF; fetch_valid = 1; fetch_xf_first = 1; step("R9 clean lsu");
    // R8 overwrite an old value with zero, then read it (R12)
    clear_in(); fetch_valid = 1; fetch_access_fault = 1; step("R8 zero");
    clear_in(); rd_addr = 12'h343; step("R12 machine");
    // R11 supervisor target
    clear_in(); trap_to_s = 1; dec_illegal = 1; dec_instr = 32'h1234_5678; step("R11 sup");
    clear_in(); rd_addr = 12'h143; step("R12 sup");
    clear_in(); rd_addr = 12'h343; step("R11 machine kept");
    clear_in(); rd_addr = 12'h7C0; step("R12 other");

    // random mix
    for (int n = 0; n < 600; n++) begin
      clear_in();
      fetch_valid = ($urandom % 3) == 0;
      fetch_pc = $urandom & 32'hFFFF_FFFE;
      fetch_xf_first = ($urandom % 4) == 0;
      fetch_upper32 = $urandom % 2;
      fetch_xf_second = ($urandom % 3) == 0;
      fetch_access_fault = ($urandom % 3) == 0;
      dec_illegal = ($urandom % 5) == 0;
      dec_instr = $urandom;
      csr_illegal = ($urandom % 7) == 0;
      lsu_valid = ($urandom % 3) == 0;
      lsu_store = $urandom % 2;
      lsu_size = 2'($urandom % 3);
      lsu_addr = $urandom;
      if ($urandom % 2) lsu_addr[1:0] = 2'b00;
      lsu_xf = ($urandom % 4) == 0;
      lsu_af = ($urandom % 4) == 0;
      trap_to_s = $urandom % 2;
      case ($urandom % 3)
        0: rd_addr = 12'h343;
        1: rd_addr = 12'h143;
        default: rd_addr = 12'($urandom);
      endcase
      step("");
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule